// File: doc/BRIEF.md
# Carry-Save Modular Multiplier

This block computes `A * B mod N` for W-bit operands, the core step of modular exponentiation in public-key arithmetic. It walks the multiplier most-significant bit first. On every iteration it doubles a redundant (sum, carry) accumulator and adds the multiplicand when the current multiplier bit is one. It also folds the accumulator back toward the modulus on that same iteration. The fold does not compare or subtract. The two top bits of each doubled vector form a small index, and that index selects a stored residue `j * 2^W mod N`. This residue replaces the dropped high part of the accumulator. Each bit slice therefore holds two full adders and an AND-gate multiplexer, and the iteration path has no long carry chain.

The residue table is built once, when a modulus is loaded, in a short fill sequence. Multiplications that follow reuse it without refilling. After the W iterations, an optional resolve stage adds the two vectors with a normal adder. It folds the bits above position W once more through the same table and makes at most two conditional subtractions of N, which yields a single binary word in `[0, N-1]`. The raw sum and carry vectors are also presented for consumers that prefer to keep the redundant form.

Top module: `csa_modmul`

## Requirements
- R1: After reset, `ready` and `done` are low and `res_sum`, `res_carry` and `res_bin` are all zero.
- R2: A `mod_load` pulse taken while no operation runs and no table fill is in progress captures `mod_in` as the modulus. The modulus must be odd with bit W-1 set. `ready` is low while the table fills and is high again after the 7th rising edge that follows the accepting edge.
- R3: A `start` pulse taken while `ready` is high (with `mod_load` low) captures `op_a` and `op_b`. `done` is high after the (W+4)th rising edge following the accepting edge.
- R4: When `done` is high, `res_bin` equals `(op_a * op_b) mod N` and is strictly less than N.
- R5: When `done` is high, `res_sum + res_carry` (each W+1 bits, read as unsigned integers) is congruent to `op_a * op_b` modulo N.
- R6: `start` is ignored while `ready` is low. No extra `done` appears, and the running operation's result is unchanged.
- R7: `mod_load` is ignored while an operation runs or a fill is in progress, and the modulus in use stays the same. If `mod_load` and `start` arrive in the same cycle, the load wins and the start is ignored.
- R8: A multiplication with an unchanged modulus does not refill the table. `ready` is already high in the cycle where `done` is high.
- R9: `done` is high for exactly one cycle per accepted operation.
- R10: `op_a` may be any W-bit value, including 0 and values at or above N. `op_b` may be any value up to N-1. The largest modulus, `2^W - 1`, is supported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_load | input | 1 | Pulse to capture a new modulus and rebuild the residue table |
| mod_in | input | W | Modulus value (odd, top bit set) |
| start | input | 1 | Pulse to begin a multiplication |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier, scanned MSB first |
| ready | output | 1 | High when a modulus is loaded and the block is idle |
| done | output | 1 | One-cycle pulse marking a valid result |
| res_sum | output | W+1 | Redundant result, sum vector |
| res_carry | output | W+1 | Redundant result, carry vector |
| res_bin | output | W | Fully reduced binary result |

## Verification
The checks take for granted that every loaded modulus is odd and has its top bit set. Only under that condition does the value after the final fold stay below 3N, so that two subtractions finish the reduction and every table entry lies below N. The stimulus builds each random modulus by forcing its lowest and highest bits to one, and it adds the two extreme legal moduli, `2^(W-1)+1` and `2^W-1`. Operands are drawn freely over W bits for A. B is kept below N, and the stimulus includes A = 0, A = N and B = N-1.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RUN  = 3'd1,
        ST_RES  = 3'd2,
        ST_FOLD = 3'd3,
        ST_SUB1 = 3'd4,
        ST_SUB2 = 3'd5
    } mm_state_e;

    // full adder: returns {carry, sum}
    function automatic logic [1:0] fadd(input logic x, input logic y, input logic z);
        return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
    endfunction

endpackage

// File: rtl/mm_cell.sv
// One bit slice of the 4:2 compression: first adder merges the two shifted
// accumulator bits with the residue bit, second adder merges that with the
// neighbour's carry and the gated multiplicand bit.
module mm_cell (
    input  logic s_i,
    input  logic c_i,
    input  logic r_i,
    input  logic a_i,
    input  logic b_i,
    input  logic k_i,
    output logic k_o,
    output logic sum_o,
    output logic cy_o
);
    import mm_pkg::*;

    logic [1:0] fa1;
    logic [1:0] fa2;
    logic       pp;

    assign pp    = a_i & b_i;
    assign fa1   = fadd(s_i, c_i, r_i);
    assign fa2   = fadd(fa1[0], k_i, pp);
    assign k_o   = fa1[1];
    assign sum_o = fa2[0];
    assign cy_o  = fa2[1];

endmodule

// File: rtl/mm_csa_row.sv
module mm_csa_row #(
    parameter int W = 32
) (
    input  logic [W-1:0] lo_s,
    input  logic [W-1:0] lo_c,
    input  logic [W-1:0] red,
    input  logic [W-1:0] a,
    input  logic         b_bit,
    output logic [W:0]   nxt_s,
    output logic [W:0]   nxt_c
);
    logic [W:0]   k;
    logic [W-1:0] sum;
    logic [W-1:0] cy;

    assign k[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_slice
        mm_cell u_cell (
            .s_i   (lo_s[i]),
            .c_i   (lo_c[i]),
            .r_i   (red[i]),
            .a_i   (a[i]),
            .b_i   (b_bit),
            .k_i   (k[i]),
            .k_o   (k[i+1]),
            .sum_o (sum[i]),
            .cy_o  (cy[i])
        );
    end

    assign nxt_s = {k[W], sum};
    assign nxt_c = {cy, 1'b0};

endmodule

// File: rtl/mm_ctable.sv
// Modulus register and residue table: entry j holds (j * 2^W) mod N.
module mm_ctable #(
    parameter int W     = 32,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [W-1:0]     mod_in,
    input  logic [IDX_W-1:0] idx_a,
    input  logic [IDX_W-1:0] idx_b,
    output logic [W-1:0]     rd_a,
    output logic [W-1:0]     rd_b,
    output logic [W-1:0]     mod_o,
    output logic             ready_o,
    output logic             busy_o
);
    localparam int TBL = 1 << IDX_W;
    localparam logic [IDX_W-1:0] J_LAST = IDX_W'(TBL - 1);

    typedef struct packed {
        logic [TBL-1:0][W-1:0] tbl;
        logic [W-1:0]          n;
        logic [W-1:0]          r;
        logic [W-1:0]          acc;
        logic [IDX_W-1:0]      j;
        logic                  filling;
        logic                  valid;
    } tab_t;

    tab_t q_q, q_d;

    logic [W:0]   sum_w;
    logic [W-1:0] nxt;

    always_comb begin
        q_d   = q_q;
        sum_w = {1'b0, q_q.acc} + {1'b0, q_q.r};
        nxt   = (sum_w >= {1'b0, q_q.n}) ? W'(sum_w - {1'b0, q_q.n}) : sum_w[W-1:0];
        if (load_i) begin
            q_d.n       = mod_in;
            q_d.r       = '0 - mod_in;
            q_d.acc     = '0;
            q_d.tbl[0]  = '0;
            q_d.j       = IDX_W'(1);
            q_d.filling = 1'b1;
            q_d.valid   = 1'b0;
        end else if (q_q.filling) begin
            q_d.tbl[q_q.j] = nxt;
            q_d.acc        = nxt;
            if (q_q.j == J_LAST) begin
                q_d.filling = 1'b0;
                q_d.valid   = 1'b1;
            end else begin
                q_d.j = q_q.j + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign rd_a    = q_q.tbl[idx_a];
    assign rd_b    = q_q.tbl[idx_b];
    assign mod_o   = q_q.n;
    assign ready_o = q_q.valid;
    assign busy_o  = q_q.filling;

    // R2: every residue read by the datapath lies below the modulus
    a_r2_entry_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.valid |-> (rd_a < q_q.n));

    // R2: a taken load withdraws readiness and starts the fill
    a_r2_load_refills: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!ready_o && busy_o));

endmodule

// File: rtl/csa_modmul.sv
module csa_modmul #(
    parameter int W       = 32,
    parameter bit RESOLVE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mod_load,
    input  logic [W-1:0] mod_in,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         ready,
    output logic         done,
    output logic [W:0]   res_sum,
    output logic [W:0]   res_carry,
    output logic [W-1:0] res_bin
);
    import mm_pkg::*;

    localparam int IDX_W = 3;
    localparam int CW    = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

    typedef struct packed {
        mm_state_e    st;
        logic [CW-1:0] cnt;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W:0]   s;
        logic [W:0]   c;
        logic [W+1:0] f;
        logic [W-1:0] res;
        logic         done;
    } regs_t;

    regs_t q_q, q_d;

    logic             tbl_ready;
    logic             tbl_busy;
    logic [W-1:0]     modv;
    logic [IDX_W-1:0] idx_it;
    logic [IDX_W-1:0] idx_fd;
    logic [W-1:0]     red_it;
    logic [W-1:0]     red_fd;
    logic [W:0]       row_s;
    logic [W:0]       row_c;
    logic [W-1:0]     lo_s;
    logic [W-1:0]     lo_c;
    logic             load_acc;
    logic             start_acc;
    logic [W+1:0]     v_sum;
    logic [W:0]       f_fold;
    logic [W+1:0]     f_sub;
    logic [W+1:0]     three_n;

    // accumulator doubled: low W bits stay, the two bits above index the table
    assign lo_s   = {q_q.s[W-2:0], 1'b0};
    assign lo_c   = {q_q.c[W-2:0], 1'b0};
    assign idx_it = {1'b0, q_q.s[W:W-1]} + {1'b0, q_q.c[W:W-1]};
    assign idx_fd = {1'b0, q_q.f[W+1:W]};

    assign ready     = tbl_ready && (q_q.st == ST_IDLE);
    assign load_acc  = mod_load && (q_q.st == ST_IDLE) && !tbl_busy;
    assign start_acc = start && ready && !mod_load;

    mm_ctable #(.W(W), .IDX_W(IDX_W)) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_acc),
        .mod_in  (mod_in),
        .idx_a   (idx_it),
        .idx_b   (idx_fd),
        .rd_a    (red_it),
        .rd_b    (red_fd),
        .mod_o   (modv),
        .ready_o (tbl_ready),
        .busy_o  (tbl_busy)
    );

    mm_csa_row #(.W(W)) u_row (
        .lo_s  (lo_s),
        .lo_c  (lo_c),
        .red   (red_it),
        .a     (q_q.a),
        .b_bit (q_q.b[W-1]),
        .nxt_s (row_s),
        .nxt_c (row_c)
    );

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        v_sum    = {1'b0, q_q.s} + {1'b0, q_q.c};
        f_fold   = {1'b0, q_q.f[W-1:0]} + {1'b0, red_fd};
        f_sub    = (q_q.f >= {2'b00, modv}) ? (q_q.f - {2'b00, modv}) : q_q.f;
        unique case (q_q.st)
            ST_IDLE: begin
                if (start_acc) begin
                    q_d.a   = op_a;
                    q_d.b   = op_b;
                    q_d.s   = '0;
                    q_d.c   = '0;
                    q_d.cnt = CNT_LAST;
                    q_d.st  = ST_RUN;
                end
            end
            ST_RUN: begin
                q_d.s = row_s;
                q_d.c = row_c;
                q_d.b = {q_q.b[W-2:0], 1'b0};
                if (q_q.cnt == '0) begin
                    if (RESOLVE) begin
                        q_d.st = ST_RES;
                    end else begin
                        q_d.st   = ST_IDLE;
                        q_d.done = 1'b1;
                    end
                end else begin
                    q_d.cnt = q_q.cnt - CW'(1);
                end
            end
            ST_RES: begin
                q_d.f  = v_sum;
                q_d.st = ST_FOLD;
            end
            ST_FOLD: begin
                q_d.f  = {1'b0, f_fold};
                q_d.st = ST_SUB1;
            end
            ST_SUB1: begin
                q_d.f  = f_sub;
                q_d.st = ST_SUB2;
            end
            ST_SUB2: begin
                q_d.f    = f_sub;
                q_d.res  = f_sub[W-1:0];
                q_d.done = 1'b1;
                q_d.st   = ST_IDLE;
            end
            default: q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign done      = q_q.done;
    assign res_sum   = q_q.s;
    assign res_carry = q_q.c;

    if (RESOLVE) begin : g_resolve
        assign res_bin = q_q.res;

        // R4: the resolved word never reaches the modulus
        a_r4_result_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (res_bin < modv));
    end else begin : g_raw
        assign res_bin = '0;
    end

    assign three_n = {2'b00, modv} + {1'b0, modv, 1'b0};

    // R4: after the final fold, two subtractions suffice (relies on top bit of N set)
    a_r4_fold_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == ST_SUB1) |-> (q_q.f < three_n));

    // R3: an accepted start withdraws readiness on the next cycle
    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> !ready);

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: modulus in use is frozen while an operation runs
    a_r7_mod_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st != ST_IDLE) |=> $stable(modv));

    // R8: no refill between operations, so readiness returns with done
    a_r8_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

endmodule

// File: tb/csa_modmul_tb.sv
`timescale 1ns/1ps
module csa_modmul_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mod_load = 1'b0;
    logic [W-1:0] mod_in = '0;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         ready;
    logic         done;
    logic [W:0]   res_sum;
    logic [W:0]   res_carry;
    logic [W-1:0] res_bin;

    always #4 clk = ~clk;

    csa_modmul #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mod_load(mod_load), .mod_in(mod_in),
        .start(start), .op_a(op_a), .op_b(op_b), .ready(ready), .done(done),
        .res_sum(res_sum), .res_carry(res_carry), .res_bin(res_bin)
    );

    typedef struct {
        logic [W-1:0] n;
        logic [W-1:0] exp;
        longint       cyc;
    } item_t;

    item_t        sbq[$];
    int           tests = 0;
    int           fails = 0;
    int           issued = 0;
    int           done_seen = 0;
    longint       cyc = 0;
    logic [W-1:0] cur_n = '0;
    logic         prev_done = 1'b0;
    bit           finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [W-1:0] n);
        logic [63:0] p;
        p = 64'(a) * 64'(b);
        return W'(p % 64'(n));
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) chk(!done, "R9 done width", 64'(done), 64'd0);
            if (done) begin
                done_seen++;
                if (sbq.size() == 0) begin
                    chk(1'b0, "R6 unexpected done", 64'd1, 64'd0);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    chk(res_bin == it.exp, "R4 res_bin", 64'(res_bin), 64'(it.exp));
                    chk(((64'(res_sum) + 64'(res_carry)) % 64'(it.n)) == 64'(it.exp),
                        "R5 redundant congruence",
                        (64'(res_sum) + 64'(res_carry)) % 64'(it.n), 64'(it.exp));
                    chk(cyc == it.cyc + W + 4, "R3 latency", 64'(cyc), 64'(it.cyc + W + 4));
                    chk(ready, "R8 ready at done", 64'(ready), 64'd1);
                end
            end
            prev_done = done;
        end
    end

    task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b);
        item_t it;
        while (!ready) @(negedge clk);
        start = 1'b1; op_a = a; op_b = b;
        @(negedge clk);
        start = 1'b0;
        it.n = cur_n; it.exp = ref_mul(a, b, cur_n); it.cyc = cyc;
        sbq.push_back(it);
        issued++;
    endtask

    task automatic wait_idle();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load_mod(input logic [W-1:0] n, input bit with_start);
        longint c0;
        mod_load = 1'b1; mod_in = n;
        if (with_start) begin start = 1'b1; op_a = 32'd5; op_b = 32'd7; end
        @(negedge clk);
        mod_load = 1'b0; start = 1'b0;
        c0 = cyc;
        cur_n = n;
        chk(!ready, "R2 ready low during fill", 64'(ready), 64'd0);
        while (!ready && cyc < c0 + 50) @(negedge clk);
        chk(cyc == c0 + 7, "R2 fill length", 64'(cyc), 64'(c0 + 7));
    endtask

    initial begin
        logic [W-1:0] n2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!ready, "R1 ready", 64'(ready), 64'd0);
        chk(!done, "R1 done", 64'(done), 64'd0);
        chk(res_bin == '0, "R1 res_bin", 64'(res_bin), 64'd0);
        chk(res_sum == '0 && res_carry == '0, "R1 raw vectors",
            64'(res_sum) | 64'(res_carry), 64'd0);

        // R6: start with no modulus loaded
        start = 1'b1; op_a = 32'd3; op_b = 32'd4;
        @(negedge clk);
        start = 1'b0;
        repeat (W + 10) @(negedge clk);
        chk(done_seen == 0, "R6 start before load", 64'(done_seen), 64'd0);

        // R10: largest modulus and corner operands
        load_mod(32'hFFFF_FFFF, 1'b0);
        do_op(32'd0, 32'hFFFF_FFFE);
        do_op(32'hFFFF_FFFE, 32'hFFFF_FFFE);
        do_op(32'hFFFF_FFFF, 32'd12345);
        do_op(32'd123456789, 32'd987654321);
        wait_idle();

        // random modulus, R10 operands including A >= N
        n2 = $urandom() | 32'h8000_0001;
        load_mod(n2, 1'b0);
        do_op(32'd0, n2 - 1);
        do_op(n2, 32'd77);
        do_op(32'hFFFF_FFFF, n2 - 1);
        for (int i = 0; i < 8; i++) do_op($urandom(), $urandom() % n2);
        wait_idle();

        // R6: start while busy is ignored
        do_op(32'hDEAD_BEEF, n2 - 3);
        repeat (5) @(negedge clk);
        start = 1'b1; op_a = 32'h1111_1111; op_b = 32'h2222_2222;
        @(negedge clk);
        start = 1'b0;
        wait_idle();

        // R7: load while busy is ignored; same modulus still in use afterwards
        do_op(32'hCAFE_F00D, 32'h1234_5678 % n2);
        repeat (4) @(negedge clk);
        mod_load = 1'b1; mod_in = 32'h8000_0001;
        @(negedge clk);
        mod_load = 1'b0;
        wait_idle();
        chk(ready, "R7 no refill after ignored load", 64'(ready), 64'd1);
        do_op(32'h0BAD_CAFE, 32'h7654_3210 % n2);
        wait_idle();

        // R7: load and start together, load wins
        load_mod(32'h8000_0001, 1'b1);
        repeat (W + 10) @(negedge clk);
        chk(done_seen == issued, "R7 start lost to load", 64'(done_seen), 64'(issued));

        // smallest legal modulus, back-to-back ops (R8)
        for (int i = 0; i < 6; i++) do_op($urandom(), $urandom() % 32'h8000_0001);
        do_op(32'h8000_0000, 32'h8000_0000);
        wait_idle();

        // another random modulus
        load_mod($urandom() | 32'h8000_0001, 1'b0);
        for (int i = 0; i < 6; i++) do_op($urandom(), $urandom() % cur_n);
        wait_idle();

        repeat (W + 10) @(negedge clk);
        chk(done_seen == issued, "R6 done count", 64'(done_seen), 64'(issued));

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL R3 watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule